// File: doc/BRIEF.md
# Scatter-Gather Link Walker

This block is the front end of one direction of a data mover. Given a table base address and a start pulse, it reads a chain of 8-byte link entries from memory through a simple single-outstanding read port. For each entry it decodes a control word and an address word, then hands one segment (start address, byte length, action code) to a downstream byte mover. It waits for that mover to report the segment finished before it fetches the next entry.

A chain ends at the entry whose end flag is set. If that entry also has its ring flag set, the walker returns to the table base and keeps going. An entry with a zero length produces no segment. An entry that is not marked valid, that has its reserved bit set, or that asks for more than the maximum segment size stops the walk and raises a sticky error flag. Entries can ask for a one-cycle interrupt pulse when their segment completes.

Top module: `sg_link_walker`

## Requirements
- R1: A start pulse while idle latches `base_addr`, raises `busy` on the next cycle and requests the control word at the base address. Reset leaves `busy`, `tbl_req`, `seg_valid`, `irq` and `inv_err` low.
- R2: The control word is decoded by bit position: bit 0 valid, bit 1 end of chain, bit 2 notify on completion, bits 5:3 action code, bit 6 ring, bit 7 reserved, bits 31:8 length in bytes. The word at entry offset +4 is the segment start address.
- R3: A valid entry with a non-zero length gives exactly one segment with `seg_addr` equal to its address word and `seg_len` equal to its length field. `seg_valid` and the segment fields stay steady until `seg_ready` is seen.
- R4: Entries are walked at consecutive 8-byte steps from the base. The next entry is read only after `seg_done` for the current segment.
- R5: After `seg_done` for an end-of-chain entry without ring, the walker returns to idle and `busy` falls.
- R6: After `seg_done` for an end-of-chain entry with ring set, the walker restarts at the latched base address.
- R7: A control word with bit 0 clear or bit 7 set issues no segment, sets `inv_err` and returns to idle. `inv_err` stays set until the next accepted start, which clears it.
- R8: A length field above `MAX_SEG` (default 0x100000) is handled like an invalid entry: no segment, `inv_err` set, walk stopped. A length equal to `MAX_SEG` is issued normally.
- R9: A valid entry with length zero issues no segment and no interrupt. Its end and ring flags still take effect.
- R10: When an entry with notify set completes, `irq` is high for exactly the one cycle after `seg_done`.
- R11: The action code of the entry is presented on `seg_op` with its segment. A start pulse while `busy` has no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk at `base_addr` (used only while idle) |
| base_addr | input | 32 | Address of the first link entry |
| busy | output | 1 | A walk is in progress |
| tbl_req | output | 1 | Table read request, held until `tbl_rvalid` |
| tbl_addr | output | 32 | Table word address being requested |
| tbl_rvalid | input | 1 | Read data valid for the held request |
| tbl_rdata | input | 32 | Table read data |
| seg_valid | output | 1 | Segment offered to the byte mover |
| seg_ready | input | 1 | Byte mover accepts the segment |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 24 | Segment length in bytes |
| seg_op | output | 3 | Segment action code |
| seg_done | input | 1 | One-cycle pulse: current segment finished |
| irq | output | 1 | One-cycle completion interrupt |
| inv_err | output | 1 | Sticky bad-entry error flag |

## Verification
The completion interrupt and the end-of-walk decision are both triggered by the same `seg_done` on the final entry. In one cycle the walker must pulse `irq` and either drop `busy` or wrap to the base. The bench gives the final entry of a chain its notify flag, then checks at the same sample point that `irq` is high while `busy` is already low. In the ring case, two notify pulses are counted across a wrap, and the third segment offered must carry the first entry's address.

// File: rtl/sgw_pkg.sv
// Package: shared constants and types for the scatter-gather link walker.
// Assumes a 32-bit control word with a 24-bit length field in bits 31:8.
package sgw_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 24;
    localparam int OP_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTL,
        ST_ADR,
        ST_ISSUE,
        ST_WAIT
    } walk_state_e;

    // Control fields kept after decode (valid/reserved are consumed by the check).
    typedef struct packed {
        logic             last;
        logic             notify;
        logic             wrap;
        logic [OP_W-1:0]  op;
        logic [LEN_W-1:0] len;
    } link_ctl_t;
endpackage

// File: rtl/sgw_ctl_decode.sv
// Module: sgw_ctl_decode
// Splits a link control word into its fields and classifies the entry as
// bad (not valid, reserved bit set, or too long) or empty (zero length).
// Assumes the control word layout fixed in sgw_pkg. Purely combinational.
module sgw_ctl_decode
    import sgw_pkg::*;
#(
    parameter int unsigned MAX_SEG = 32'h0010_0000
) (
    input  logic [WORD_W-1:0] word,
    output link_ctl_t         ctl,
    output logic              bad,
    output logic              empty
);
    logic too_long;

    // Field extraction by bit position.
    always_comb begin
        ctl.last   = word[1];
        ctl.notify = word[2];
        ctl.op     = word[5:3];
        ctl.wrap   = word[6];
        ctl.len    = word[WORD_W-1:8];
    end

    // The length limit is only needed when the field can exceed it.
    generate
        if (MAX_SEG < (64'd1 << LEN_W)) begin : g_len_chk
            assign too_long = ({8'd0, word[WORD_W-1:8]} > MAX_SEG);
        end else begin : g_no_len_chk
            assign too_long = 1'b0;
        end
    endgenerate

    // Entry classification.
    always_comb begin
        bad   = !word[0] || word[7] || too_long;
        empty = (word[WORD_W-1:8] == '0);
    end
endmodule

// File: rtl/sgw_ptr.sv
// Module: sgw_ptr
// Holds the latched table base and the current entry pointer, and forms the
// table word address (control word or address word of the entry).
// Assumes load, adv and wrap are mutually exclusive single-cycle strobes.
module sgw_ptr #(
    parameter int ADDR_W      = 32,
    parameter int ENTRY_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              adv,
    input  logic              wrap,
    input  logic              hi_sel,
    output logic [ADDR_W-1:0] tbl_addr
);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(ENTRY_BYTES);
    localparam logic [ADDR_W-1:0] HI_OFFS = ADDR_W'(ENTRY_BYTES / 2);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;

    // Base latch and entry pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (load) begin
            base_q <= base;
            ptr_q  <= base;
        end else if (wrap) begin
            ptr_q  <= base_q;
        end else if (adv) begin
            ptr_q  <= ptr_q + STEP;
        end
    end

    // Word select within the entry.
    assign tbl_addr = hi_sel ? (ptr_q + HI_OFFS) : ptr_q;
endmodule

// File: rtl/sgw_fsm.sv
// Module: sgw_fsm
// Sequencer of the walker: fetches the two words of each entry, offers the
// segment, waits for completion, and decides advance, wrap, stop or error.
// Assumes one table read outstanding at a time and that seg_done arrives only
// for an accepted segment.
module sgw_fsm
    import sgw_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int unsigned MAX_SEG = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tbl_rvalid,
    input  logic [WORD_W-1:0] tbl_rdata,
    input  link_ctl_t         ctl_in,
    input  logic              ctl_bad,
    input  logic              ctl_empty,
    input  logic              seg_ready,
    input  logic              seg_done,
    output logic              busy,
    output logic              tbl_req,
    output logic              hi_sel,
    output logic              seg_valid,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic [OP_W-1:0]   seg_op,
    output logic              irq,
    output logic              inv_err,
    output logic              ptr_load,
    output logic              ptr_adv,
    output logic              ptr_wrap
);
    walk_state_e       state_q;
    link_ctl_t         ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic              irq_q;
    logic              err_q;
    logic              step_ev;
    logic              step_last;
    logic              step_ring;

    // Entry-finished event and the flags that steer it.
    always_comb begin
        step_ev   = 1'b0;
        step_last = ctl_q.last;
        step_ring = ctl_q.wrap;
        if (state_q == ST_CTL && tbl_rvalid && !ctl_bad && ctl_empty) begin
            step_ev   = 1'b1;
            step_last = ctl_in.last;
            step_ring = ctl_in.wrap;
        end else if (state_q == ST_WAIT && seg_done) begin
            step_ev   = 1'b1;
        end
        ptr_load = (state_q == ST_IDLE) && start;
        ptr_adv  = step_ev && !step_last;
        ptr_wrap = step_ev && step_last && step_ring;
    end

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            addr_q  <= '0;
            irq_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    err_q   <= 1'b0;
                    state_q <= ST_CTL;
                end
                ST_CTL: if (tbl_rvalid) begin
                    ctl_q <= ctl_in;
                    if (ctl_bad) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (ctl_empty) begin
                        state_q <= (ctl_in.last && !ctl_in.wrap) ? ST_IDLE : ST_CTL;
                    end else begin
                        state_q <= ST_ADR;
                    end
                end
                ST_ADR: if (tbl_rvalid) begin
                    addr_q  <= tbl_rdata[ADDR_W-1:0];
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: if (seg_ready) begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: if (seg_done) begin
                    irq_q   <= ctl_q.notify;
                    state_q <= (ctl_q.last && !ctl_q.wrap) ? ST_IDLE : ST_CTL;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode.
    assign busy      = (state_q != ST_IDLE);
    assign tbl_req   = (state_q == ST_CTL) || (state_q == ST_ADR);
    assign hi_sel    = (state_q == ST_ADR);
    assign seg_valid = (state_q == ST_ISSUE);
    assign seg_addr  = addr_q;
    assign seg_len   = ctl_q.len;
    assign seg_op    = ctl_q.op;
    assign irq       = irq_q;
    assign inv_err   = err_q;

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && tbl_req && !inv_err));
    // R3
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));
    // R9
    seg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0));
    // R8
    seg_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> ({8'd0, seg_len} <= MAX_SEG));
    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R7
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_err) |-> (!busy && !seg_valid));
    // R4
    no_read_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> !tbl_req);
endmodule

// File: rtl/sg_link_walker.sv
// Module: sg_link_walker (top)
// Walks a table of 8-byte scatter-gather link entries and issues one segment
// per non-empty entry to a downstream byte mover, with ring and error handling.
// Assumes the table read port returns data for a held request, one at a time.
module sg_link_walker
    import sgw_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          ENTRY_BYTES = 8,
    parameter int unsigned MAX_SEG     = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              tbl_req,
    output logic [ADDR_W-1:0] tbl_addr,
    input  logic              tbl_rvalid,
    input  logic [WORD_W-1:0] tbl_rdata,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic [OP_W-1:0]   seg_op,
    input  logic              seg_done,
    output logic              irq,
    output logic              inv_err
);
    link_ctl_t ctl_dec;
    logic      ctl_bad;
    logic      ctl_empty;
    logic      hi_sel;
    logic      ptr_load;
    logic      ptr_adv;
    logic      ptr_wrap;

    sgw_ctl_decode #(.MAX_SEG(MAX_SEG)) u_dec (
        .word  (tbl_rdata),
        .ctl   (ctl_dec),
        .bad   (ctl_bad),
        .empty (ctl_empty)
    );

    sgw_ptr #(.ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .base     (base_addr),
        .adv      (ptr_adv),
        .wrap     (ptr_wrap),
        .hi_sel   (hi_sel),
        .tbl_addr (tbl_addr)
    );

    sgw_fsm #(.ADDR_W(ADDR_W), .MAX_SEG(MAX_SEG)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tbl_rvalid (tbl_rvalid),
        .tbl_rdata  (tbl_rdata),
        .ctl_in     (ctl_dec),
        .ctl_bad    (ctl_bad),
        .ctl_empty  (ctl_empty),
        .seg_ready  (seg_ready),
        .seg_done   (seg_done),
        .busy       (busy),
        .tbl_req    (tbl_req),
        .hi_sel     (hi_sel),
        .seg_valid  (seg_valid),
        .seg_addr   (seg_addr),
        .seg_len    (seg_len),
        .seg_op     (seg_op),
        .irq        (irq),
        .inv_err    (inv_err),
        .ptr_load   (ptr_load),
        .ptr_adv    (ptr_adv),
        .ptr_wrap   (ptr_wrap)
    );
endmodule

// File: tb/sg_link_walker_tb.sv
`timescale 1ns/1ps
module sg_link_walker_tb;
    localparam int DONE_LAT = 3;
    localparam int WDOG     = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic        busy;
    logic        tbl_req;
    logic [31:0] tbl_addr;
    logic        tbl_rvalid = 1'b0;
    logic [31:0] tbl_rdata = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b1;
    logic [31:0] seg_addr;
    logic [23:0] seg_len;
    logic [2:0]  seg_op;
    logic        seg_done = 1'b0;
    logic        irq;
    logic        inv_err;

    logic [31:0] mem [0:63];
    int          nchk = 0;
    int          nfail = 0;
    int          nseg = 0;
    int          nirq = 0;
    int          done_cnt = 0;
    int          cyc_total = 0;
    logic        irq_at_idle = 1'b0;
    logic [31:0] log_addr [0:7];
    logic [23:0] log_len [0:7];
    logic [2:0]  log_op [0:7];

    always #4 clk = ~clk;

    sg_link_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .busy(busy), .tbl_req(tbl_req), .tbl_addr(tbl_addr),
        .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_op(seg_op), .seg_done(seg_done),
        .irq(irq), .inv_err(inv_err)
    );

    // Table memory: answers a held request one cycle later, then idles a cycle.
    always @(posedge clk) begin
        tbl_rvalid <= tbl_req && !tbl_rvalid;
        tbl_rdata  <= mem[tbl_addr[7:2]];
    end

    // Byte-mover model and observation, away from the active edge.
    always @(negedge clk) begin
        seg_done = 1'b0;
        if (done_cnt > 0) begin
            done_cnt = done_cnt - 1;
            if (done_cnt == 0) seg_done = 1'b1;
        end
        if (seg_valid && seg_ready) begin
            if (nseg < 8) begin
                log_addr[nseg] = seg_addr;
                log_len[nseg]  = seg_len;
                log_op[nseg]   = seg_op;
            end
            nseg = nseg + 1;
            done_cnt = DONE_LAT;
        end
        if (irq) nirq = nirq + 1;
        if (irq && !busy) irq_at_idle = 1'b1;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc_total = cyc_total + 1;
        if (cyc_total > WDOG) begin
            nchk = nchk + 1;
            nfail = nfail + 1;
            $display("FAIL R1 watchdog: act=%0d cycles exp<%0d", cyc_total, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    function automatic logic [31:0] mkw0(input logic [23:0] len, input logic ring,
                                         input logic [2:0] op, input logic nfy,
                                         input logic last, input logic v);
        return {len, 1'b0, ring, op, nfy, last, v};
    endfunction

    typedef struct packed {
        logic [31:0] w0;
        logic [31:0] w1;
        logic [3:0]  nseg;
        logic [3:0]  nirq;
        logic        err;
        logic [2:0]  op;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{mkw0(24'd16, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1), 32'h0000_1000, 4'd1, 4'd0, 1'b0, 3'd0},
        '{mkw0(24'h100000, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1), 32'h0000_2000, 4'd1, 4'd1, 1'b0, 3'd0},
        '{mkw0(24'd8, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0), 32'h0000_3000, 4'd0, 4'd0, 1'b1, 3'd0},
        '{mkw0(24'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1), 32'h0000_4000, 4'd0, 4'd0, 1'b0, 3'd0},
        '{mkw0(24'h100001, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1), 32'h0000_5000, 4'd0, 4'd0, 1'b1, 3'd0},
        '{mkw0(24'd3, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1), 32'h0000_6000, 4'd1, 4'd0, 1'b0, 3'd5},
        '{mkw0(24'd4, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1) | 32'h80, 32'h0000_7000, 4'd0, 4'd0, 1'b1, 3'd0},
        '{mkw0(24'd9, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1), 32'h0000_8000, 4'd1, 4'd1, 1'b0, 3'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        nseg = 0;
        nirq = 0;
        irq_at_idle = 1'b0;
    endtask

    task automatic pulse_start(input logic [31:0] base);
        @(negedge clk);
        base_addr = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        chk("R1 tbl_req after reset", {31'd0, tbl_req}, 32'd0);
        chk("R1 seg_valid after reset", {31'd0, seg_valid}, 32'd0);
        chk("R1 irq/inv_err after reset", {30'd0, irq, inv_err}, 32'd0);

        // Single-entry vectors at base 0x100 (memory index 0).
        for (int i = 0; i < 8; i++) begin
            mem[0] = VECS[i].w0;
            mem[1] = VECS[i].w1;
            clear_obs();
            pulse_start(32'h100);
            chk("R1 busy after start", {31'd0, busy}, 32'd1);
            chk("R7 error cleared by start", {31'd0, inv_err}, 32'd0);
            wait_idle();
            chk("R3 R9 segment count", nseg, {28'd0, VECS[i].nseg});
            chk("R10 irq count", nirq, {28'd0, VECS[i].nirq});
            chk("R7 R8 error flag", {31'd0, inv_err}, {31'd0, VECS[i].err});
            if (VECS[i].nseg == 4'd1) begin
                chk("R3 segment address", log_addr[0], VECS[i].w1);
                chk("R2 segment length", {8'd0, log_len[0]}, {8'd0, VECS[i].w0[31:8]});
                chk("R11 action code", {29'd0, log_op[0]}, {29'd0, VECS[i].op});
            end
        end

        // R4 R5 R9 chain with an empty entry; start while busy is ignored (R11).
        mem[16] = mkw0(24'd8, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1); mem[17] = 32'h10;
        mem[18] = mkw0(24'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1); mem[19] = 32'h20;
        mem[20] = mkw0(24'd4, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1); mem[21] = 32'h30;
        mem[22] = mkw0(24'd2, 1'b0, 3'd3, 1'b1, 1'b1, 1'b1); mem[23] = 32'h40;
        clear_obs();
        pulse_start(32'h140);
        repeat (6) @(negedge clk);
        pulse_start(32'h180);
        wait_idle();
        chk("R4 chain segment count", nseg, 32'd3);
        chk("R4 first address", log_addr[0], 32'h10);
        chk("R9 empty entry skipped", log_addr[1], 32'h30);
        chk("R11 start while busy ignored", log_addr[2], 32'h40);
        chk("R10 R9 irq count", nirq, 32'd2);
        chk("R5 irq with busy low", {31'd0, irq_at_idle}, 32'd1);
        chk("R5 stopped", {31'd0, busy}, 32'd0);

        // R7 invalid entry mid-chain at base 0x1C0 (index 48).
        mem[48] = mkw0(24'd5, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1); mem[49] = 32'h50;
        mem[50] = 32'h0; mem[51] = 32'h55;
        clear_obs();
        pulse_start(32'h1C0);
        wait_idle();
        chk("R7 segments before bad entry", nseg, 32'd1);
        chk("R7 error set mid-chain", {31'd0, inv_err}, 32'd1);

        // R6 ring wrap at base 0x140.
        mem[16] = mkw0(24'd6, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1); mem[17] = 32'h60;
        mem[18] = mkw0(24'd7, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1); mem[19] = 32'h70;
        clear_obs();
        pulse_start(32'h140);
        while (nseg < 2) @(negedge clk);
        seg_ready = 1'b0;
        while (!seg_valid) @(negedge clk);
        chk("R6 wrapped to base entry", seg_addr, 32'h60);
        mem[18] = mkw0(24'd7, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1);
        seg_ready = 1'b1;
        wait_idle();
        chk("R6 ring segment count", nseg, 32'd4);
        chk("R6 last address", log_addr[3], 32'h70);
        chk("R10 ring irq count", nirq, 32'd2);
        chk("R6 no error", {31'd0, inv_err}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule